// File: doc/BRIEF.md
# Dual-Channel DAC Command Decoder

This block interprets 16-bit command frames for a two-channel voltage-output converter. Each channel holds a staging (input) register and an output (DAC) register. The 3-bit opcode at the top of a frame selects one of three actions for the channels:

- stage new data in a channel's input register only;
- stage new data and then refresh the DAC registers;
- refresh the DAC registers from the staged values, without taking new data.

One opcode value opens a second decode level. It handles per-channel shutdown, a general-purpose logic output, the output-edge mode bit used by the serial front end, and single-channel refreshes.

The serial shifter sits in front of this block and delivers an assembled frame with a one-cycle strobe. The analog ladder consumes the two 13-bit DAC register values and the two shutdown flags. A lockout input, when low, blocks shutdown. When the lockout input falls, it wakes any channel that is shut down at once, without waiting for a clock, and the DAC contents are kept. An asynchronous active-low clear and the power-on reset return every register to its idle value.

Top module: `dac_cmd_decoder`

## Requirements
- R1: Power-on reset (`rst_ni` low) or clear (`clr_ni` low) asynchronously sets:
  - both input registers and both DAC outputs to 0;
  - both shutdown flags, `upo_o` and `dout_rise_o` to 0.
- R2: Without `frame_valid_i` high at a rising clock edge, no output changes, whatever `frame_i` holds. The exceptions are the asynchronous effects of R1 and R9.
- R3: Frame layout and the stage-only opcodes:
  - the opcode is `frame_i[15:13]` and the data is `frame_i[12:0]`;
  - opcode 001 writes the data into input register A, and opcode 101 writes it into input register B;
  - neither changes any DAC output.
- R4: Opcode 010 writes the data to input register A and DAC A, and copies input register B into DAC B. Opcode 110 does the mirror operation: it writes the data to input register B and DAC B, and copies input register A into DAC A.
- R5: Opcode 011 writes the data into both input registers and both DAC registers.
- R6: Refresh from the staged values:
  - opcode 100 copies both input registers into their DAC registers;
  - with opcode 000, the sub-command is `frame_i[12:10]`;
  - sub-command 001 copies input A into DAC A only, and sub-command 101 copies input B into DAC B only.
- R7: Shutdown when `pdl_i` is high:
  - opcode 111 shuts down both channels;
  - sub-command 110 shuts down channel A, and sub-command 111 shuts down channel B;
  - input and DAC registers keep their contents.
- R8: A command that writes a channel's DAC register clears that channel's shutdown flag in the same edge.
- R9: While `pdl_i` is low, both shutdown flags are 0 and shutdown commands have no effect. A falling `pdl_i` clears the flags without a clock edge.
- R10: Sub-command 011 drives `upo_o` high, and sub-command 010 drives it low.
- R11: Sub-command 100 loads `dout_rise_o` from `frame_i[9]`:
  - 1 selects the rising-edge output mode;
  - 0 selects the falling-edge output mode.
- R12: Sub-command 000 changes no output or register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Power-on reset, asynchronous, active low |
| clr_ni | input | 1 | Clear, asynchronous, active low |
| pdl_i | input | 1 | Shutdown lockout, low blocks and cancels shutdown |
| frame_i | input | 16 | Assembled command frame |
| frame_valid_i | input | 1 | One-cycle strobe marking a frame to execute |
| dac_a_o | output | 13 | DAC register A contents |
| dac_b_o | output | 13 | DAC register B contents |
| shdn_a_o | output | 1 | Channel A in shutdown (output high impedance) |
| shdn_b_o | output | 1 | Channel B in shutdown (output high impedance) |
| upo_o | output | 1 | User-programmable logic output |
| dout_rise_o | output | 1 | Serial data-out edge mode, 1 = rising |

## Verification
A corrupted input register is invisible at the ports until a refresh command copies it into a DAC register. For that reason the bench stages values and later refreshes them, so that a wrong staged value shows on the first DAC output compared after the refresh edge. Errors in DAC registers, shutdown flags, `upo_o` and the mode bit show on the very next clock after the faulty command. The lockout wake and the clear act without a clock, so they are checked one nanosecond after the input moves, not at an edge.

// File: rtl/dac_cmd_pkg.sv
package dac_cmd_pkg;
  localparam int unsigned DATA_W = 13;
  localparam int unsigned OP_W   = 3;
  localparam int unsigned NCH    = 2;

  typedef enum logic [OP_W-1:0] {
    OP_EXT     = 3'b000,
    OP_LD_A    = 3'b001,
    OP_LDUP_A  = 3'b010,
    OP_WR_BOTH = 3'b011,
    OP_UP_BOTH = 3'b100,
    OP_LD_B    = 3'b101,
    OP_LDUP_B  = 3'b110,
    OP_SD_BOTH = 3'b111
  } op_e;

  typedef enum logic [OP_W-1:0] {
    SUB_NOP    = 3'b000,
    SUB_UP_A   = 3'b001,
    SUB_UPO_LO = 3'b010,
    SUB_UPO_HI = 3'b011,
    SUB_MODE   = 3'b100,
    SUB_UP_B   = 3'b101,
    SUB_SD_A   = 3'b110,
    SUB_SD_B   = 3'b111
  } sub_e;

  typedef enum logic [1:0] {
    SRC_HOLD  = 2'd0,
    SRC_INREG = 2'd1,
    SRC_DATA  = 2'd2
  } dac_src_e;

  typedef struct packed {
    logic [NCH-1:0]     load_in;
    dac_src_e [NCH-1:0] src;
    logic [NCH-1:0]     sd_req;
    logic               upo_wr;
    logic               upo_val;
    logic               mode_wr;
  } ctl_t;
endpackage

// File: rtl/dac_cmd_decode.sv
module dac_cmd_decode
  import dac_cmd_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic [DW+OP_W-1:0] frame_i,
  output ctl_t               ctl_o
);
  localparam int unsigned FW = DW + OP_W;

  op_e  op;
  sub_e sub;
  assign op  = op_e'(frame_i[FW-1 -: OP_W]);
  assign sub = sub_e'(frame_i[DW-1 -: OP_W]);

  always_comb begin
    ctl_o = '0;
    unique case (op)
      OP_LD_A:    ctl_o.load_in[0] = 1'b1;
      OP_LD_B:    ctl_o.load_in[1] = 1'b1;
      OP_LDUP_A: begin
        ctl_o.load_in[0] = 1'b1;
        ctl_o.src[0]     = SRC_DATA;
        ctl_o.src[1]     = SRC_INREG;
      end
      OP_LDUP_B: begin
        ctl_o.load_in[1] = 1'b1;
        ctl_o.src[1]     = SRC_DATA;
        ctl_o.src[0]     = SRC_INREG;
      end
      OP_WR_BOTH: begin
        ctl_o.load_in = '1;
        ctl_o.src[0]  = SRC_DATA;
        ctl_o.src[1]  = SRC_DATA;
      end
      OP_UP_BOTH: begin
        ctl_o.src[0] = SRC_INREG;
        ctl_o.src[1] = SRC_INREG;
      end
      OP_SD_BOTH: ctl_o.sd_req = '1;
      OP_EXT: begin
        unique case (sub)
          SUB_UP_A:   ctl_o.src[0]    = SRC_INREG;
          SUB_UP_B:   ctl_o.src[1]    = SRC_INREG;
          SUB_SD_A:   ctl_o.sd_req[0] = 1'b1;
          SUB_SD_B:   ctl_o.sd_req[1] = 1'b1;
          SUB_UPO_LO: ctl_o.upo_wr    = 1'b1;
          SUB_UPO_HI: begin
            ctl_o.upo_wr  = 1'b1;
            ctl_o.upo_val = 1'b1;
          end
          SUB_MODE:   ctl_o.mode_wr   = 1'b1;
          default:    ;
        endcase
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/dac_chan.sv
module dac_chan
  import dac_cmd_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sd_rst_ni,
  input  logic          cmd_valid_i,
  input  logic          load_in_i,
  input  dac_src_e      src_i,
  input  logic          sd_req_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] dac_o,
  output logic          sd_o
);
  logic [DW-1:0] in_q, dac_q;
  logic          sd_q;
  logic          dac_wr;

  assign dac_wr = cmd_valid_i && (src_i != SRC_HOLD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q  <= '0;
      dac_q <= '0;
    end else if (cmd_valid_i) begin
      if (load_in_i) in_q <= data_i;
      unique case (src_i)
        SRC_INREG: dac_q <= in_q;
        SRC_DATA:  dac_q <= data_i;
        default:   ;
      endcase
    end
  end

  // sd_rst_ni folds in the lockout: low pdl wakes at once and blocks entry
  always_ff @(posedge clk_i or negedge sd_rst_ni) begin
    if (!sd_rst_ni)                   sd_q <= 1'b0;
    else if (dac_wr)                  sd_q <= 1'b0;
    else if (cmd_valid_i && sd_req_i) sd_q <= 1'b1;
  end

  assign dac_o = dac_q;
  assign sd_o  = sd_q;
endmodule

// File: rtl/dac_cmd_decoder.sv
module dac_cmd_decoder
  import dac_cmd_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_ni,
  input  logic               pdl_i,
  input  logic [DW+OP_W-1:0] frame_i,
  input  logic               frame_valid_i,
  output logic [DW-1:0]      dac_a_o,
  output logic [DW-1:0]      dac_b_o,
  output logic               shdn_a_o,
  output logic               shdn_b_o,
  output logic               upo_o,
  output logic               dout_rise_o
);
  localparam int unsigned MODE_BIT = DW - OP_W - 1;

  ctl_t          ctl;
  logic          rst_all_n, sd_rst_n;
  logic [DW-1:0] dac_w [NCH];
  logic [NCH-1:0] sd_w;
  logic          upo_q, mode_q;

  assign rst_all_n = rst_ni & clr_ni;
  assign sd_rst_n  = rst_all_n & pdl_i;

  dac_cmd_decode #(.DW(DW)) u_dec (
    .frame_i (frame_i),
    .ctl_o   (ctl)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dac_chan #(.DW(DW)) u_ch (
      .clk_i       (clk_i),
      .rst_ni      (rst_all_n),
      .sd_rst_ni   (sd_rst_n),
      .cmd_valid_i (frame_valid_i),
      .load_in_i   (ctl.load_in[c]),
      .src_i       (ctl.src[c]),
      .sd_req_i    (ctl.sd_req[c]),
      .data_i      (frame_i[DW-1:0]),
      .dac_o       (dac_w[c]),
      .sd_o        (sd_w[c])
    );
  end

  always_ff @(posedge clk_i or negedge rst_all_n) begin
    if (!rst_all_n) begin
      upo_q  <= 1'b0;
      mode_q <= 1'b0;
    end else if (frame_valid_i) begin
      if (ctl.upo_wr)  upo_q  <= ctl.upo_val;
      if (ctl.mode_wr) mode_q <= frame_i[MODE_BIT];
    end
  end

  assign dac_a_o     = dac_w[0];
  assign dac_b_o     = dac_w[1];
  assign shdn_a_o    = sd_w[0];
  assign shdn_b_o    = sd_w[1];
  assign upo_o       = upo_q;
  assign dout_rise_o = mode_q;
endmodule

// File: rtl/dac_cmd_decoder_chk.sv
module dac_cmd_decoder_chk #(
  parameter int unsigned DW = 13
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          clr_ni,
  input logic          pdl_i,
  input logic [DW+2:0] frame_i,
  input logic          frame_valid_i,
  input logic [DW-1:0] dac_a_o,
  input logic [DW-1:0] dac_b_o,
  input logic          shdn_a_o,
  input logic          shdn_b_o,
  input logic          upo_o,
  input logic          dout_rise_o
);
  logic [2:0] op, sub;
  assign op  = frame_i[DW+2:DW];
  assign sub = frame_i[DW-1:DW-3];

  assert_idle_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni || !clr_ni)
    !frame_valid_i |=> $stable(dac_a_o) && $stable(dac_b_o) && $stable(upo_o) && $stable(dout_rise_o));

  assert_stage_only_R3: assert property (@(posedge clk_i) disable iff (!rst_ni || !clr_ni)
    frame_valid_i && (op == 3'b001 || op == 3'b101) |=> $stable(dac_a_o) && $stable(dac_b_o));

  assert_write_both_R5: assert property (@(posedge clk_i) disable iff (!rst_ni || !clr_ni)
    frame_valid_i && op == 3'b011 |=>
      dac_a_o == $past(frame_i[DW-1:0]) && dac_b_o == $past(frame_i[DW-1:0]));

  assert_sd_both_R7: assert property (@(posedge clk_i) disable iff (!rst_ni || !clr_ni)
    frame_valid_i && op == 3'b111 && pdl_i |=> !pdl_i || (shdn_a_o && shdn_b_o));

  assert_wake_on_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni || !clr_ni)
    frame_valid_i && op == 3'b011 |=> !shdn_a_o && !shdn_b_o);

  assert_lockout_R9: assert property (@(posedge clk_i) disable iff (!rst_ni || !clr_ni)
    !pdl_i |-> !shdn_a_o && !shdn_b_o);

  assert_upo_high_R10: assert property (@(posedge clk_i) disable iff (!rst_ni || !clr_ni)
    frame_valid_i && op == 3'b000 && sub == 3'b011 |=> upo_o);
endmodule

bind dac_cmd_decoder dac_cmd_decoder_chk #(.DW(DW)) u_chk (.*);

// File: tb/dac_cmd_decoder_bench.sv
`timescale 1ns/1ps
module dac_cmd_decoder_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0, clr_ni = 1'b1, pdl_i = 1'b1;
  logic [15:0] frame_i = '0;
  logic        frame_valid_i = 1'b0;
  logic [12:0] dac_a_o, dac_b_o;
  logic        shdn_a_o, shdn_b_o, upo_o, dout_rise_o;

  int total = 0, bad = 0;
  int m_in_a, m_in_b, m_dac_a, m_dac_b;
  bit m_sd_a, m_sd_b, m_upo, m_mode;

  always #4 clk_i = ~clk_i;

  dac_cmd_decoder u_dac_cmd_decoder (.*);

  task automatic model_reset();
    m_in_a = 0; m_in_b = 0; m_dac_a = 0; m_dac_b = 0;
    m_sd_a = 0; m_sd_b = 0; m_upo = 0; m_mode = 0;
  endtask

  task automatic model_cmd(int op, int d);
    int sub = (d >> 10) & 7;
    case (op)
      1: m_in_a = d;
      5: m_in_b = d;
      2: begin m_in_a = d; m_dac_a = d; m_dac_b = m_in_b; m_sd_a = 0; m_sd_b = 0; end
      6: begin m_in_b = d; m_dac_b = d; m_dac_a = m_in_a; m_sd_a = 0; m_sd_b = 0; end
      3: begin m_in_a = d; m_in_b = d; m_dac_a = d; m_dac_b = d; m_sd_a = 0; m_sd_b = 0; end
      4: begin m_dac_a = m_in_a; m_dac_b = m_in_b; m_sd_a = 0; m_sd_b = 0; end
      7: if (pdl_i) begin m_sd_a = 1; m_sd_b = 1; end
      default: case (sub)
        1: begin m_dac_a = m_in_a; m_sd_a = 0; end
        5: begin m_dac_b = m_in_b; m_sd_b = 0; end
        6: if (pdl_i) m_sd_a = 1;
        7: if (pdl_i) m_sd_b = 1;
        2: m_upo = 0;
        3: m_upo = 1;
        4: m_mode = d[9];
        default: ;
      endcase
    endcase
  endtask

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_all(string req);
    chk(req, "dac_a", dac_a_o, m_dac_a);
    chk(req, "dac_b", dac_b_o, m_dac_b);
    chk(req, "shdn_a", shdn_a_o, m_sd_a & pdl_i);
    chk(req, "shdn_b", shdn_b_o, m_sd_b & pdl_i);
    chk(req, "upo", upo_o, m_upo);
    chk(req, "mode", dout_rise_o, m_mode);
  endtask

  task automatic send(string req, int op, int d);
    @(negedge clk_i);
    frame_i = 16'((op << 13) | (d & 16'h1fff));
    frame_valid_i = 1'b1;
    model_cmd(op, d & 16'h1fff);
    @(negedge clk_i);
    frame_valid_i = 1'b0;
    check_all(req);
  endtask

  task automatic idle(string req, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      frame_i = 16'hffff ^ 16'(i * 16'h1357);
      check_all(req);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk_i);
    check_all("R1");
    rst_ni = 1'b1;
    idle("R1", 1);

    // R3: stage only, DACs hold
    send("R3", 1, 13'h0aaa);
    send("R3", 5, 13'h1555);
    idle("R2", 3);
    // R6: refresh both exposes staged values
    send("R6", 4, 0);
    // R4: stage one, refresh both
    send("R4", 2, 13'h0123);
    send("R3", 5, 13'h0777);
    send("R4", 6, 13'h1fff);
    // R5
    send("R5", 3, 13'h0f0f);
    // R7 / R8
    send("R3", 1, 13'h0042);
    send("R7", 7, 0);
    send("R8", 0, 13'h0400);
    send("R8", 0, 13'h1400);
    send("R7", 0, 13'h1800);
    send("R7", 0, 13'h1c00);
    send("R3", 5, 13'h0999);
    send("R6", 0, 13'h1400);
    // R9: lockout falls mid-cycle, wake without clock
    send("R7", 7, 0);
    @(negedge clk_i); #2;
    pdl_i = 1'b0; #1;
    check_all("R9");
    m_sd_a = 0; m_sd_b = 0;
    send("R9", 7, 0);
    send("R9", 0, 13'h1800);
    @(negedge clk_i); pdl_i = 1'b1;
    idle("R9", 2);
    // R10 / R11 / R12
    send("R10", 0, 13'h0c00);
    send("R10", 0, 13'h0800);
    send("R10", 0, 13'h0c00);
    send("R11", 0, 13'h1200);
    send("R11", 0, 13'h1000);
    send("R11", 0, 13'h13ff);
    send("R12", 0, 13'h03ff);
    idle("R2", 4);
    // R1: asynchronous clear mid-cycle
    send("R7", 0, 13'h1800);
    #2 clr_ni = 1'b0; #1;
    model_reset();
    check_all("R1");
    @(negedge clk_i); clr_ni = 1'b1;
    idle("R1", 1);
    send("R6", 4, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule